// File: doc/BRIEF.md
# Display Controller Register and Interrupt Block

This block is the register file and interrupt source of a framebuffer display controller. A host reaches it over a simple 32-bit bus with word-aligned single-cycle reads and writes. It stores four timing words, the base addresses of the upper and lower panel halves, a control word and an interrupt mask. It keeps a raw interrupt status and drives one level-sensitive interrupt line.

Other display logic reads several values straight from the block's outputs: the panel width and height decoded from the timing words, the pixel-depth code, and the enable state. While the display is enabled, an internal frame timer ticks once every `FRAME_CYCLES` clock cycles. Each tick sets two status bits together. A strap input `swap_ctl_mask` exchanges the addresses of the control and mask registers, so that software written for either register layout can run unchanged.

Top module: `dispctl_regs`

## Requirements
- R1: After a synchronous active-low reset, every readable register, the status and the mask are 0. `irq` and `disp_en` are low, the width output is 16 and the height output is 1.
- R2: Word offsets 0..3 (byte addresses 0x00..0x0C) hold timing words 0..3 and offsets 4 and 5 hold the upper and lower base addresses. Each reads back the last value written to it. Reads at offsets 11 and 12 return the upper and lower base address.
- R3: With `swap_ctl_mask` low, offset 6 is the interrupt mask and offset 7 is control. With it high, offset 6 is control and offset 7 is the mask. Reads follow the same mapping.
- R4: `disp_en` is 1 exactly when control bit 0 and control bit 11 are both 1. `depth_code` equals control bits 3:1.
- R5: `panel_width` = ((timing0 AND 0xFC) + 4) × 4 and `panel_height` = timing1[9:0] + 1.
- R6: A control write that leaves the display enabled restarts the frame timer. While the display stays enabled, status bits 2 and 3 are both set at the clock edge `FRAME_CYCLES` cycles after that write's edge, and again every `FRAME_CYCLES` cycles after that.
- R7: While the display is disabled, no tick occurs and status does not change from ticks. Rewriting control with the display enabled restarts the full period.
- R8: Offset 8 reads raw status and offset 9 reads status AND mask.
- R9: A write to offset 10 clears every status bit that is 1 in the written value and leaves the other bits unchanged.
- R10: `irq` is high whenever status AND mask is nonzero. It follows mask writes and clear writes on the clock edge of the write.
- R11: Reads at byte addresses 0xFE0 + 4k (k = 0..7) return byte k of parameter `ID_BYTES`, counting from the least significant byte, in bits 7:0, with the upper bits 0.
- R12: Reads at any other offset return 0. Writes to offsets 8, 9, 11, 12 and to any undecoded offset change no register and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| swap_ctl_mask | input | 1 | Strap that exchanges the control and mask offsets |
| irq | output | 1 | Level interrupt |
| panel_width | output | 11 | Decoded width in pixels |
| panel_height | output | 11 | Decoded height in lines |
| depth_code | output | 3 | Pixel-depth code from control |
| disp_en | output | 1 | Display enabled |

## Verification
Random data is written to the storage registers, including control and mask under a random strap value. These writes check the address map and the strap exchange. They also show whether width and height are decoded from the right bit fields, because random values fill the bits that the decode must ignore. Directed sequences then sample status one cycle before and exactly at the expected tick edge, both after enabling and after a mid-frame restart. This separates an off-by-one period from a timer that ignores the restart. Single-bit enables, partial clears, mask changes and writes to read-only or undecoded offsets show whether each status bit and the interrupt respond only to their own causes.

// File: rtl/dispctl_pkg.sv
// Package: shared offsets and constants of the display register block.
// Assumes a 12-bit byte address decoded on 32-bit words.
package dispctl_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int WIDX_W = ADDR_W - 2;
    localparam int DIM_W  = 11;

    localparam logic [WIDX_W-1:0] OFS_TIM0  = 10'd0;
    localparam logic [WIDX_W-1:0] OFS_TIM3  = 10'd3;
    localparam logic [WIDX_W-1:0] OFS_UPB   = 10'd4;
    localparam logic [WIDX_W-1:0] OFS_LPB   = 10'd5;
    localparam logic [WIDX_W-1:0] OFS_SLOTA = 10'd6;
    localparam logic [WIDX_W-1:0] OFS_SLOTB = 10'd7;
    localparam logic [WIDX_W-1:0] OFS_RAW   = 10'd8;
    localparam logic [WIDX_W-1:0] OFS_MSKD  = 10'd9;
    localparam logic [WIDX_W-1:0] OFS_CLR   = 10'd10;
    localparam logic [WIDX_W-1:0] OFS_UPCUR = 10'd11;
    localparam logic [WIDX_W-1:0] OFS_LPCUR = 10'd12;
    localparam logic [WIDX_W-1:0] OFS_IDLO  = 10'h3F8;

    localparam int BIT_EN   = 0;
    localparam int BIT_PWR  = 11;
    localparam int BIT_NEXT = 2;
    localparam int BIT_VCMP = 3;
endpackage

// File: rtl/dispctl_geom.sv
// Module: decodes panel width and height from timing-word fields.
// Assumes the caller passes only the relevant timing bits; pure logic.
module dispctl_geom
    import dispctl_pkg::*;
(
    input  logic [5:0]       ppl_field,
    input  logic [9:0]       lpp_field,
    output logic [DIM_W-1:0] width_o,
    output logic [DIM_W-1:0] height_o
);
    // Width is (field + 1) * 16; height is field + 1.
    always_comb begin
        width_o  = {(DIM_W-4)'({1'b0, ppl_field} + 7'd1), 4'b0000};
        height_o = DIM_W'({1'b0, lpp_field} + 11'd1);
    end
endmodule

// File: rtl/dispctl_frame_tick.sv
// Module: free-running frame timer giving a one-cycle tick every PERIOD
// cycles while enabled. Assumes PERIOD >= 2; restart zeroes the phase.
module dispctl_frame_tick #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles of the frame; hold at zero when off or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick on the last cycle of each frame.
    always_comb tick_o = en_i && !restart_i && (cnt_q == LAST);

    // R6: ticks are isolated single-cycle pulses.
    a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    // R7: after the timer is off or restarted, the next cycle has no tick.
    a_r7_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || restart_i) |=> !tick_o);
endmodule

// File: rtl/dispctl_irq.sv
// Module: raw status, mask and level interrupt. Set requests win over
// clears in the same cycle. Assumes single-cycle write strobes.
module dispctl_irq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_val,
    input  logic         mask_we,
    input  logic [W-1:0] mask_val,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] status_q, mask_q;

    // Update status from clears and sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~(clr_we ? clr_val : '0)) | set_i;
        end
    end

    // Hold the interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_val;
        end
    end

    // Level interrupt from pending enabled bits.
    always_comb begin
        status_o = status_q;
        mask_o   = mask_q;
        irq_o    = |(status_q & mask_q);
    end

    // R6: every requested bit is set on the next cycle.
    a_r6_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));
    // R9: a clear without a concurrent set removes the written bits.
    a_r9_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && set_i == '0) |=> ((status_o & $past(clr_val)) == '0));
    // R10: the interrupt rises only after a mask write or a set.
    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mask_we || set_i != '0));
endmodule

// File: rtl/dispctl_regs.sv
// Module: bus register file of the display controller. Decodes word
// offsets, swaps control/mask slots by strap, reads combinationally.
// Assumes word-aligned single-cycle accesses on bus_sel.
module dispctl_regs
    import dispctl_pkg::*;
#(
    parameter int          FRAME_CYCLES = 1000,
    parameter logic [63:0] ID_BYTES     = 64'h7E_3A_C4_19_00_52_21_6D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              swap_ctl_mask,
    output logic              irq,
    output logic [DIM_W-1:0]  panel_width,
    output logic [DIM_W-1:0]  panel_height,
    output logic [2:0]        depth_code,
    output logic              disp_en
);
    localparam int N_TIM = 4;

    logic [WIDX_W-1:0] widx;
    logic              wr_any;
    logic [DATA_W-1:0] tim_q [N_TIM];
    logic [DATA_W-1:0] upb_q, lpb_q, ctrl_q;
    logic [WIDX_W-1:0] ctrl_ofs, mask_ofs;
    logic              ctrl_we, mask_we, clr_we;
    logic [DATA_W-1:0] status, mask, set_vec;
    logic              tick;
    logic [2:0]        id_k;

    // Decode the word offset and the write strobes.
    always_comb begin
        widx     = bus_addr[ADDR_W-1:2];
        wr_any   = bus_sel && bus_wr;
        ctrl_ofs = swap_ctl_mask ? OFS_SLOTA : OFS_SLOTB;
        mask_ofs = swap_ctl_mask ? OFS_SLOTB : OFS_SLOTA;
        ctrl_we  = wr_any && (widx == ctrl_ofs);
        mask_we  = wr_any && (widx == mask_ofs);
        clr_we   = wr_any && (widx == OFS_CLR);
        id_k     = widx[2:0];
    end

    // One storage word per timing register.
    for (genvar g = 0; g < N_TIM; g++) begin : g_tim
        // Capture timing word g on its own offset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tim_q[g] <= '0;
            end else if (wr_any && widx == WIDX_W'(g)) begin
                tim_q[g] <= bus_wdata;
            end
        end
    end

    // Capture base addresses and control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upb_q  <= '0;
            lpb_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_any && widx == OFS_UPB) upb_q <= bus_wdata;
            if (wr_any && widx == OFS_LPB) lpb_q <= bus_wdata;
            if (ctrl_we)                   ctrl_q <= bus_wdata;
        end
    end

    // Drive control-derived outputs.
    always_comb begin
        disp_en    = ctrl_q[BIT_EN] && ctrl_q[BIT_PWR];
        depth_code = ctrl_q[3:1];
        set_vec    = '0;
        set_vec[BIT_NEXT] = tick;
        set_vec[BIT_VCMP] = tick;
    end

    dispctl_geom u_geom (
        .ppl_field (tim_q[0][7:2]),
        .lpp_field (tim_q[1][9:0]),
        .width_o   (panel_width),
        .height_o  (panel_height)
    );

    dispctl_frame_tick #(.PERIOD(FRAME_CYCLES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (disp_en),
        .restart_i (ctrl_we),
        .tick_o    (tick)
    );

    dispctl_irq #(.W(DATA_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_we   (clr_we),
        .clr_val  (bus_wdata),
        .mask_we  (mask_we),
        .mask_val (bus_wdata),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq)
    );

    // Read multiplexer over the word offset.
    always_comb begin
        bus_rdata = '0;
        if (widx >= OFS_IDLO) begin
            bus_rdata = {24'b0, ID_BYTES[{id_k, 3'b000} +: 8]};
        end else if (widx <= OFS_TIM3) begin
            bus_rdata = tim_q[widx[1:0]];
        end else if (widx == ctrl_ofs) begin
            bus_rdata = ctrl_q;
        end else if (widx == mask_ofs) begin
            bus_rdata = mask;
        end else begin
            case (widx)
                OFS_UPB, OFS_UPCUR: bus_rdata = upb_q;
                OFS_LPB, OFS_LPCUR: bus_rdata = lpb_q;
                OFS_RAW:            bus_rdata = status;
                OFS_MSKD:           bus_rdata = status & mask;
                default:            bus_rdata = '0;
            endcase
        end
    end

    // R5: width is always a nonzero multiple of 16.
    a_r5_width_granule: assert property (@(posedge clk) disable iff (!rst_n)
        (panel_width[3:0] == 4'b0) && (panel_width != '0));
    // R7: the display turns on only through a control write.
    a_r7_enable_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_en) |-> $past(ctrl_we));
    // R4: while enabled, control cannot have its enable bits cleared silently.
    a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && !ctrl_we) |=> disp_en);
endmodule

// File: tb/test_dispctl_regs.sv
module test_dispctl_regs;
    localparam int          CLK_PERIOD = 10;
    localparam int          FRAME      = 40;
    localparam logic [63:0] IDV        = 64'hA5_0F_C3_81_42_17_E9_6B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        swap_ctl_mask = 1'b0;
    logic        irq, disp_en;
    logic [10:0] panel_width, panel_height;
    logic [2:0]  depth_code;

    int total = 0, bad = 0;

    logic [31:0] m_tim [4];
    logic [31:0] m_upb, m_lpb, m_ctrl, m_mask, m_stat;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispctl_regs #(.FRAME_CYCLES(FRAME), .ID_BYTES(IDV)) i_dispctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .swap_ctl_mask(swap_ctl_mask), .irq(irq), .panel_width(panel_width),
        .panel_height(panel_height), .depth_code(depth_code), .disp_en(disp_en)
    );

    function automatic logic [31:0] exp_width(input logic [31:0] t0);
        return ((t0 & 32'hFC) + 32'd4) * 32'd4;
    endfunction
    function automatic logic [31:0] exp_height(input logic [31:0] t1);
        return {22'b0, t1[9:0]} + 32'd1;
    endfunction
    function automatic logic [31:0] exp_id(input int k);
        return {24'b0, IDV[8*k +: 8]};
    endfunction
    function automatic logic exp_en(input logic [31:0] c);
        return c[0] & c[11];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic chk_all_regs(input string req);
        for (int i = 0; i < 4; i++) rd_chk(req, 12'(4*i), m_tim[i]);
        rd_chk(req, 12'h10, m_upb);
        rd_chk(req, 12'h14, m_lpb);
        rd_chk(req, swap_ctl_mask ? 12'h18 : 12'h1C, m_ctrl);
        rd_chk(req, swap_ctl_mask ? 12'h1C : 12'h18, m_mask);
        rd_chk(req, 12'h20, m_stat);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2718));
        for (int i = 0; i < 4; i++) m_tim[i] = '0;
        m_upb = '0; m_lpb = '0; m_ctrl = '0; m_mask = '0; m_stat = '0;
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk_all_regs("R1");
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 en", {31'b0, disp_en}, 32'd0);
        check("R1 width", {21'b0, panel_width}, 32'd16);
        check("R1 height", {21'b0, panel_height}, 32'd1);

        // R2 R3 R4 R5: random register traffic, display kept off.
        for (int it = 0; it < 160; it++) begin
            int sel;
            logic [31:0] v;
            sel = int'($urandom % 8);
            v = $urandom;
            swap_ctl_mask = 1'($urandom);
            if (sel < 4) begin
                wr(12'(4*sel), v); m_tim[sel] = v;
                rd_chk("R2 timing", 12'(4*sel), v);
            end else if (sel == 4) begin
                wr(12'h10, v); m_upb = v;
                rd_chk("R2 upper", 12'h10, v);
                rd_chk("R2 upper mirror", 12'h2C, v);
            end else if (sel == 5) begin
                wr(12'h14, v); m_lpb = v;
                rd_chk("R2 lower", 12'h14, v);
                rd_chk("R2 lower mirror", 12'h30, v);
            end else if (sel == 6) begin
                v = v & ~32'h800;
                wr(swap_ctl_mask ? 12'h18 : 12'h1C, v); m_ctrl = v;
                rd_chk("R3 ctrl slot", swap_ctl_mask ? 12'h18 : 12'h1C, v);
                rd_chk("R3 mask slot", swap_ctl_mask ? 12'h1C : 12'h18, m_mask);
                check("R4 depth", {29'b0, depth_code}, {29'b0, v[3:1]});
                check("R4 en", {31'b0, disp_en}, 32'd0);
            end else begin
                wr(swap_ctl_mask ? 12'h1C : 12'h18, v); m_mask = v;
                rd_chk("R3 mask slot", swap_ctl_mask ? 12'h1C : 12'h18, v);
                rd_chk("R3 ctrl slot", swap_ctl_mask ? 12'h18 : 12'h1C, m_ctrl);
                check("R10 irq idle", {31'b0, irq}, 32'd0);
            end
            check("R5 width", {21'b0, panel_width}, exp_width(m_tim[0]));
            check("R5 height", {21'b0, panel_height}, exp_height(m_tim[1]));
        end

        // R5: extreme timing fields.
        wr(12'h00, 32'hFFFF_FFFF); m_tim[0] = 32'hFFFF_FFFF;
        wr(12'h04, 32'hFFFF_FC00); m_tim[1] = 32'hFFFF_FC00;
        check("R5 width max", {21'b0, panel_width}, 32'd1024);
        check("R5 height min", {21'b0, panel_height}, 32'd1);
        wr(12'h04, 32'h0000_03FF); m_tim[1] = 32'h3FF;
        check("R5 height max", {21'b0, panel_height}, 32'd1024);

        swap_ctl_mask = 1'b0;
        wr(12'h18, 32'h0); m_mask = 0;

        // R6: first tick exactly FRAME cycles after enable write.
        wr(12'h1C, 32'h0000_0807); m_ctrl = 32'h807;
        check("R4 en on", {31'b0, disp_en}, {31'b0, exp_en(m_ctrl)});
        check("R4 depth on", {29'b0, depth_code}, 32'd3);
        wait_cycles(FRAME - 1);
        rd_chk("R6 before tick", 12'h20, 32'h0);
        wait_cycles(1);
        rd_chk("R6 at tick", 12'h20, 32'hC);
        check("R10 masked off", {31'b0, irq}, 32'd0);
        wr(12'h28, 32'hFFFF_FFFF);
        rd_chk("R9 clear all", 12'h20, 32'h0);
        wait_cycles(FRAME - 2);
        rd_chk("R6 period before", 12'h20, 32'h0);
        wait_cycles(1);
        rd_chk("R6 second tick", 12'h20, 32'hC);

        // R7: disabled timer stays quiet.
        wr(12'h1C, 32'h0); m_ctrl = 0;
        wr(12'h28, 32'hFFFF_FFFF);
        wait_cycles(2 * FRAME);
        rd_chk("R7 stopped", 12'h20, 32'h0);

        // R7: a control rewrite restarts the period.
        wr(12'h1C, 32'h0000_0801); m_ctrl = 32'h801;
        wait_cycles(FRAME / 2);
        wr(12'h1C, 32'h0000_0801);
        wait_cycles(FRAME - 1);
        rd_chk("R7 restart before", 12'h20, 32'h0);
        wait_cycles(1);
        rd_chk("R7 restart tick", 12'h20, 32'hC);
        wr(12'h1C, 32'h0); m_ctrl = 0; m_stat = 32'hC;

        // R8 R9 R10: masking, partial clears and the interrupt.
        rd_chk("R8 raw", 12'h20, 32'hC);
        rd_chk("R8 masked none", 12'h24, 32'h0);
        wr(12'h18, 32'h4); m_mask = 32'h4;
        check("R10 irq on mask", {31'b0, irq}, 32'd1);
        rd_chk("R8 masked next", 12'h24, 32'h4);
        wr(12'h28, 32'h4); m_stat = 32'h8;
        rd_chk("R9 partial", 12'h20, 32'h8);
        check("R10 irq after clear", {31'b0, irq}, 32'd0);
        wr(12'h18, 32'h8); m_mask = 32'h8;
        check("R10 irq vcmp", {31'b0, irq}, 32'd1);
        rd_chk("R8 masked vcmp", 12'h24, 32'h8);
        wr(12'h28, 32'h8); m_stat = 0;
        check("R10 irq cleared", {31'b0, irq}, 32'd0);

        // R4 R7: a single enable bit does not start the timer.
        wr(12'h1C, 32'h0000_0001); m_ctrl = 32'h1;
        check("R4 bit0 only", {31'b0, disp_en}, 32'd0);
        wait_cycles(2 * FRAME);
        rd_chk("R7 bit0 only", 12'h20, 32'h0);
        wr(12'h1C, 32'h0000_0800); m_ctrl = 32'h800;
        check("R4 bit11 only", {31'b0, disp_en}, 32'd0);
        wait_cycles(2 * FRAME);
        rd_chk("R7 bit11 only", 12'h20, 32'h0);

        // R12: read-only and undecoded writes change nothing.
        wr(12'h20, 32'hFFFF_FFFF);
        wr(12'h24, 32'hFFFF_FFFF);
        wr(12'h2C, 32'hFFFF_FFFF);
        wr(12'h30, 32'hFFFF_FFFF);
        wr(12'h34, 32'hFFFF_FFFF);
        wr(12'h3C, 32'hFFFF_FFFF);
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'hFE0, 32'hFFFF_FFFF);
        chk_all_regs("R12 no change");
        check("R12 irq", {31'b0, irq}, 32'd0);
        rd_chk("R12 hole 13", 12'h34, 32'h0);
        rd_chk("R12 hole 15", 12'h3C, 32'h0);
        rd_chk("R12 hole 0x200", 12'h200, 32'h0);
        rd_chk("R12 hole 0xFDC", 12'hFDC, 32'h0);
        rd_chk("R12 clear reads 0", 12'h28, 32'h0);

        // R11: identification bytes.
        for (int k = 0; k < 8; k++) rd_chk("R11 id", 12'(12'hFE0 + 4*k), exp_id(k));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule